// File: doc/BRIEF.md
# 64-bit Global Timer with Self-Rearming Comparator

This block is a free-running 64-bit up-counter with one 64-bit compare channel, reached through a 32-bit register bus. Software sees the counter and the compare value as lower and upper 32-bit halves. When the counter equals the compare value and the comparator is on, a sticky event flag is raised. The interrupt line carries that flag gated by an enable bit. In periodic mode the comparator adds a 32-bit step to its own compare value at every match, so events recur at a fixed spacing with no software action.

Writes to the counter halves, the compare halves, the step register and the control register pass through a fixed internal synchronisation delay of `SYNC_DELAY` cycles (4 by default) before they take effect. In the cycle a write lands, a sticky per-register completion bit is set. Software polls that bit to learn that its write has landed, and clears it by writing a one to it. Writes to the interrupt enable, to the event flag and to the completion registers act on the next clock edge. Reads are combinational from the address.

Top module: `gtimer_cmp64`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: While control bit 8 (offset 0x240) is one, the 64-bit counter adds one per cycle and carries from the lower half (0x100) into the upper half (0x104). While that bit is zero the counter holds its value.
- R3: A write to 0x100, 0x104, 0x200, 0x204, 0x208 or 0x240 is visible exactly `SYNC_DELAY` edges after the edge that accepted it. Reads before that return the old value.
- R4: Completion bits are sticky and are cleared by writing one to the bit. Register 0x110 bit 0 reports the counter-low write and bit 1 the counter-high write. Register 0x24C bits 0, 1, 2 and 16 report the compare-low, compare-high, step and control writes. Each bit sets in the cycle its write takes effect, and a set wins over a clear in the same cycle.
- R5: With control bit 0 set and counter equal to compare, event flag bit 0 of 0x244 is set on the next edge, whatever the interrupt enable is.
- R6: With control bit 1 also set, each match adds the 32-bit step (0x208, zero-extended) to the 64-bit compare value, so matches recur every step cycles.
- R7: Writing one to bit 0 of 0x244 clears the event flag on the next edge, unless a match sets it in that same cycle.
- R8: `irq` is the event flag ANDed with bit 0 of 0x248. A write to 0x248 takes effect on the next edge.
- R9: Reads of unmapped offsets return zero, and writes to them change no register and set no completion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The hardest case to reach from the ports is a periodic match sequence whose cycle of occurrence is known exactly. This needs the counter, compare and step values to have all landed through the delay line before the counter is started. The bench stops the counter, loads it and the compare channel, waits out the delay, and then starts counting with one control write. From there it predicts each match edge from the start edge plus the delay. A second hard case is a clear of the event flag racing a match. Stopping the counter on the compare value holds the match for many cycles, so the clear meets a live match.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_CNT_LO = 12'h100;
  localparam logic [OFS_W-1:0] OFS_CNT_HI = 12'h104;
  localparam logic [OFS_W-1:0] OFS_CNT_WS = 12'h110;
  localparam logic [OFS_W-1:0] OFS_CMP_LO = 12'h200;
  localparam logic [OFS_W-1:0] OFS_CMP_HI = 12'h204;
  localparam logic [OFS_W-1:0] OFS_STEP   = 12'h208;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h240;
  localparam logic [OFS_W-1:0] OFS_EVT    = 12'h244;
  localparam logic [OFS_W-1:0] OFS_IEN    = 12'h248;
  localparam logic [OFS_W-1:0] OFS_GWS    = 12'h24C;

  typedef enum logic [2:0] {
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_STEP,
    SEL_CTRL
  } wsel_e;

  typedef struct packed {
    logic              vld;
    wsel_e             sel;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/gcnt_wr_sync.sv
module gcnt_wr_sync
  import gcnt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_req_t req_in,
  output wr_req_t req_out
);
  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      wr_req_t src;
      wr_req_t q;
      if (k == 0) begin : g_head
        assign src = req_in;
      end else begin : g_body
        assign src = g_stage[k-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else begin
          q.vld <= src.vld;
          if (src.vld) begin
            q.sel  <= src.sel;
            q.data <= src.data;
          end
        end
      end
    end
  endgenerate

  assign req_out = g_stage[DEPTH-1].q;
endmodule

// File: rtl/gcnt_counter.sv
module gcnt_counter #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = run | ld_lo | ld_hi;
    cnt_nxt = cnt_q;
    if (ld_lo) begin
      cnt_nxt[HALF_W-1:0] = ld_data;
    end else if (ld_hi) begin
      cnt_nxt[CNT_W-1:HALF_W] = ld_data;
    end else if (run) begin
      cnt_nxt = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gcnt_compare.sv
module gcnt_compare #(
  parameter int CMP_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMP_W-1:0]  cnt,
  input  logic              cmp_on,
  input  logic              rearm,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_step,
  input  logic [HALF_W-1:0] ld_data,
  input  logic              evt_clr,
  output logic [CMP_W-1:0]  cmp_val,
  output logic [HALF_W-1:0] step_val,
  output logic              hit,
  output logic              evt
);
  logic [CMP_W-1:0]  cmp_q, cmp_nxt;
  logic [HALF_W-1:0] step_q;
  logic              evt_q, evt_nxt;
  logic              cmp_en;

  assign hit = cmp_on && (cnt == cmp_q);

  always_comb begin
    cmp_nxt = cmp_q;
    cmp_en  = 1'b0;
    if (ld_lo) begin
      cmp_nxt[HALF_W-1:0] = ld_data;
      cmp_en = 1'b1;
    end else if (ld_hi) begin
      cmp_nxt[CMP_W-1:HALF_W] = ld_data;
      cmp_en = 1'b1;
    end else if (hit && rearm) begin
      cmp_nxt = cmp_q + CMP_W'(step_q);
      cmp_en  = 1'b1;
    end
    evt_nxt = hit | (evt_q & ~evt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      step_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (cmp_en) begin
        cmp_q <= cmp_nxt;
      end
      if (ld_step) begin
        step_q <= ld_data;
      end
      evt_q <= evt_nxt;
    end
  end

  assign cmp_val  = cmp_q;
  assign step_val = step_q;
  assign evt      = evt_q;
endmodule

// File: rtl/gcnt_sticky.sv
module gcnt_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] st
);
  logic [N-1:0] st_q, st_nxt;

  always_comb begin
    st_nxt = set | (st_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_nxt;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/gtimer_cmp64.sv
module gtimer_cmp64
  import gcnt_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SYNC_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  // address decode
  logic hit_cnt_lo, hit_cnt_hi, hit_cmp_lo, hit_cmp_hi, hit_step, hit_ctrl;
  logic hit_evt, hit_ien, hit_cws, hit_gws;
  always_comb begin
    hit_cnt_lo = bus_addr == ADDR_W'(OFS_CNT_LO);
    hit_cnt_hi = bus_addr == ADDR_W'(OFS_CNT_HI);
    hit_cmp_lo = bus_addr == ADDR_W'(OFS_CMP_LO);
    hit_cmp_hi = bus_addr == ADDR_W'(OFS_CMP_HI);
    hit_step   = bus_addr == ADDR_W'(OFS_STEP);
    hit_ctrl   = bus_addr == ADDR_W'(OFS_CTRL);
    hit_evt    = bus_addr == ADDR_W'(OFS_EVT);
    hit_ien    = bus_addr == ADDR_W'(OFS_IEN);
    hit_cws    = bus_addr == ADDR_W'(OFS_CNT_WS);
    hit_gws    = bus_addr == ADDR_W'(OFS_GWS);
  end

  // delayed write path
  wr_req_t req_in, req_ap;
  always_comb begin
    req_in      = '0;
    req_in.data = bus_wdata;
    req_in.sel  = SEL_CNT_LO;
    if (bus_we) begin
      if (hit_cnt_lo) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_CNT_LO;
      end else if (hit_cnt_hi) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_CNT_HI;
      end else if (hit_cmp_lo) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_CMP_LO;
      end else if (hit_cmp_hi) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_CMP_HI;
      end else if (hit_step) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_STEP;
      end else if (hit_ctrl) begin
        req_in.vld = 1'b1;
        req_in.sel = SEL_CTRL;
      end
    end
  end

  gcnt_wr_sync #(.DEPTH(SYNC_DELAY)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req_in  (req_in),
    .req_out (req_ap)
  );

  logic ap_cnt_lo, ap_cnt_hi, ap_cmp_lo, ap_cmp_hi, ap_step, ap_ctrl;
  always_comb begin
    ap_cnt_lo = req_ap.vld && (req_ap.sel == SEL_CNT_LO);
    ap_cnt_hi = req_ap.vld && (req_ap.sel == SEL_CNT_HI);
    ap_cmp_lo = req_ap.vld && (req_ap.sel == SEL_CMP_LO);
    ap_cmp_hi = req_ap.vld && (req_ap.sel == SEL_CMP_HI);
    ap_step   = req_ap.vld && (req_ap.sel == SEL_STEP);
    ap_ctrl   = req_ap.vld && (req_ap.sel == SEL_CTRL);
  end

  // control and interrupt enable
  logic run_q, rearm_q, cmp_on_q, ien_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q    <= 1'b0;
      rearm_q  <= 1'b0;
      cmp_on_q <= 1'b0;
    end else if (ap_ctrl) begin
      run_q    <= req_ap.data[8];
      rearm_q  <= req_ap.data[1];
      cmp_on_q <= req_ap.data[0];
    end
  end

  logic ien_ld;
  assign ien_ld = bus_we && hit_ien;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ien_q <= 1'b0;
    end else if (ien_ld) begin
      ien_q <= bus_wdata[0];
    end
  end

  // counter and comparator
  logic [CNT_W-1:0]  cnt_q, cmp_q;
  logic [DATA_W-1:0] step_q;
  logic              hit, evt_q, evt_clr;

  assign evt_clr = bus_we && hit_evt && bus_wdata[0];

  gcnt_counter #(.CNT_W(CNT_W), .HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (run_q),
    .ld_lo   (ap_cnt_lo),
    .ld_hi   (ap_cnt_hi),
    .ld_data (req_ap.data),
    .cnt     (cnt_q)
  );

  gcnt_compare #(.CMP_W(CNT_W), .HALF_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cnt      (cnt_q),
    .cmp_on   (cmp_on_q),
    .rearm    (rearm_q),
    .ld_lo    (ap_cmp_lo),
    .ld_hi    (ap_cmp_hi),
    .ld_step  (ap_step),
    .ld_data  (req_ap.data),
    .evt_clr  (evt_clr),
    .cmp_val  (cmp_q),
    .step_val (step_q),
    .hit      (hit),
    .evt      (evt_q)
  );

  // completion flags
  logic [1:0] cws_set, cws_clr, cws_q;
  logic [3:0] gws_set, gws_clr, gws_q;
  always_comb begin
    cws_set = {ap_cnt_hi, ap_cnt_lo};
    cws_clr = (bus_we && hit_cws) ? bus_wdata[1:0] : 2'b00;
    gws_set = {ap_ctrl, ap_step, ap_cmp_hi, ap_cmp_lo};
    gws_clr = (bus_we && hit_gws) ? {bus_wdata[16], bus_wdata[2:0]} : 4'b0000;
  end

  gcnt_sticky #(.N(2)) u_cws (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set   (cws_set),
    .clr   (cws_clr),
    .st    (cws_q)
  );

  gcnt_sticky #(.N(4)) u_gws (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set   (gws_set),
    .clr   (gws_clr),
    .st    (gws_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_cnt_lo)      bus_rdata = cnt_q[DATA_W-1:0];
    else if (hit_cnt_hi) bus_rdata = cnt_q[CNT_W-1:DATA_W];
    else if (hit_cws)    bus_rdata = {30'b0, cws_q};
    else if (hit_cmp_lo) bus_rdata = cmp_q[DATA_W-1:0];
    else if (hit_cmp_hi) bus_rdata = cmp_q[CNT_W-1:DATA_W];
    else if (hit_step)   bus_rdata = step_q;
    else if (hit_ctrl)   bus_rdata = {23'b0, run_q, 6'b0, rearm_q, cmp_on_q};
    else if (hit_evt)    bus_rdata = {31'b0, evt_q};
    else if (hit_ien)    bus_rdata = {31'b0, ien_q};
    else if (hit_gws)    bus_rdata = {15'b0, gws_q[3], 13'b0, gws_q[2:0]};
  end

  assign irq = evt_q & ien_q;
endmodule

// File: rtl/gcnt_chk.sv
module gcnt_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] step,
  input logic        run,
  input logic        cnt_ld,
  input logic        cmp_ld,
  input logic        hit,
  input logic        rearm,
  input logic        evt,
  input logic        ien,
  input logic        ctrl_ld,
  input logic        ctrl_done,
  input logic        irq
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run && !cnt_ld) |=> (cnt == $past(cnt) + 64'd1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run && !cnt_ld) |=> $stable(cnt));

  assert_rearm_add_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit && rearm && !cmp_ld) |=> (cmp == $past(cmp) + {32'b0, $past(step)}));

  assert_evt_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit |=> evt);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (evt && ien));

  assert_ctrl_done_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_ld |=> ctrl_done);
endmodule

bind gtimer_cmp64 gcnt_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cnt       (cnt_q),
  .cmp       (cmp_q),
  .step      (step_q),
  .run       (run_q),
  .cnt_ld    (ap_cnt_lo | ap_cnt_hi),
  .cmp_ld    (ap_cmp_lo | ap_cmp_hi),
  .hit       (hit),
  .rearm     (rearm_q),
  .evt       (evt_q),
  .ien       (ien_q),
  .ctrl_ld   (ap_ctrl),
  .ctrl_done (gws_q[3]),
  .irq       (irq)
);

// File: tb/sim_gtimer_cmp64.sv
`timescale 1ns/1ps
module sim_gtimer_cmp64;
  localparam int AW = 12;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 54;

  logic          clk = 1'b0;
  logic          rst_n, bus_we, irq;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  gtimer_cmp64 #(.ADDR_W(AW), .SYNC_DELAY(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // entry: {op, requirement number, offset, data or expected value}
  localparam logic [49:0] VEC [NV] = '{
    {OP_RD, 4'd1, 12'h240, 32'h0},        // R1 control
    {OP_RD, 4'd1, 12'h100, 32'h0},        // R1 counter
    {OP_RD, 4'd1, 12'h244, 32'h0},        // R1 event flag
    {OP_RD, 4'd1, 12'h24C, 32'h0},        // R1 completion
    {OP_WR, 4'd3, 12'h100, 32'h50},
    {OP_RD, 4'd3, 12'h100, 32'h0},        // R3 one edge later: old
    {OP_RD, 4'd4, 12'h110, 32'h0},        // R4 not yet done
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_RD, 4'd3, 12'h100, 32'h0},        // R3 three edges later: old
    {OP_RD, 4'd3, 12'h100, 32'h50},       // R3 four edges later: new
    {OP_RD, 4'd4, 12'h110, 32'h1},        // R4 low-half done
    {OP_WR, 4'd4, 12'h110, 32'h1},
    {OP_RD, 4'd4, 12'h110, 32'h0},        // R4 cleared
    {OP_WR, 4'd3, 12'h104, 32'h7},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_RD, 4'd3, 12'h104, 32'h7},        // R3 upper half
    {OP_RD, 4'd4, 12'h110, 32'h2},        // R4 high-half done
    {OP_WR, 4'd9, 12'h300, 32'hFFFFFFFF},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_RD, 4'd9, 12'h300, 32'h0},        // R9 unmapped read
    {OP_RD, 4'd9, 12'h24C, 32'h0},        // R9 no completion bit
    {OP_WR, 4'd4, 12'h110, 32'h2},
    {OP_WR, 4'd5, 12'h200, 32'h50},
    {OP_WR, 4'd5, 12'h204, 32'h7},
    {OP_WR, 4'd5, 12'h208, 32'h0},
    {OP_WR, 4'd5, 12'h240, 32'h1},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_RD, 4'd4, 12'h24C, 32'h10007},    // R4 compare, step, control done
    {OP_RD, 4'd5, 12'h244, 32'h1},        // R5 match with enable low
    {OP_IRQ, 4'd8, 12'h000, 32'h0},       // R8 gated off
    {OP_WR, 4'd8, 12'h248, 32'h1},
    {OP_IRQ, 4'd8, 12'h000, 32'h1},       // R8 gated on
    {OP_RD, 4'd8, 12'h248, 32'h1},        // R8 enable readback
    {OP_WR, 4'd7, 12'h244, 32'h1},
    {OP_RD, 4'd7, 12'h244, 32'h1},        // R7 live match wins over clear
    {OP_WR, 4'd7, 12'h240, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WT, 4'd0, 12'h000, 32'h0},
    {OP_WR, 4'd7, 12'h244, 32'h1},
    {OP_RD, 4'd7, 12'h244, 32'h0},        // R7 cleared
    {OP_IRQ, 4'd8, 12'h000, 32'h0},       // R8 low after clear
    {OP_WR, 4'd4, 12'h24C, 32'h10007},
    {OP_RD, 4'd4, 12'h24C, 32'h0}         // R4 all cleared
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo, hi;
    int  rise [3];
    int  nrise;
    bit  clr_pend, prev;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][49:48])
        OP_WR:  wr(VEC[i][43:32], VEC[i][31:0]);
        OP_RD:  rd(VEC[i][43:32], VEC[i][31:0], $sformatf("R%0d vec%0d", VEC[i][47:44], i));
        OP_WT:  @(negedge clk);
        default: begin
          chk($sformatf("R%0d vec%0d irq", VEC[i][47:44], i), {31'b0, irq}, VEC[i][31:0]);
          @(negedge clk);
        end
      endcase
    end

    // R2: carry across the half boundary while running
    wr(12'h100, 32'hFFFFFFF0);
    wr(12'h104, 32'h0);
    repeat (5) @(negedge clk);
    wr(12'h240, 32'h100);
    repeat (30) @(negedge clk);
    peek(12'h100, lo);
    peek(12'h104, hi);
    chk("R2 low after carry", lo, 32'hA);
    chk("R2 high after carry", hi, 32'h1);
    wr(12'h240, 32'h0);
    repeat (5) @(negedge clk);
    peek(12'h100, lo);
    @(negedge clk);
    peek(12'h100, hi);
    chk("R2 stopped counter holds", hi, lo);

    // R6: periodic matches
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'd20);
    wr(12'h204, 32'h0);
    wr(12'h208, 32'd10);
    wr(12'h244, 32'h1);
    wr(12'h248, 32'h1);
    repeat (5) @(negedge clk);
    rd(12'h24C, 32'h10007, "R4 step and compare done");
    wr(12'h240, 32'h103);
    nrise = 0; clr_pend = 1'b0; prev = 1'b0;
    for (int m = 1; m <= 50; m++) begin
      if (clr_pend) begin
        bus_we = 1'b1; bus_addr = 12'h244; bus_wdata = 32'h1;
      end
      @(negedge clk);
      bus_we = 1'b0;
      clr_pend = 1'b0;
      if (irq && !prev) begin
        if (nrise < 3) rise[nrise] = m;
        nrise++;
        clr_pend = 1'b1;
      end
      prev = irq;
    end
    chk("R6 match count", nrise, 3);
    chk("R6 first match edge", rise[0], 25);
    chk("R6 second match edge", rise[1], 35);
    chk("R6 third match edge", rise[2], 45);

    // R1: reset in mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rd(12'h240, 32'h0, "R1 control in reset");
    rd(12'h100, 32'h0, "R1 counter in reset");
    rd(12'h208, 32'h0, "R1 step in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule